// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between a variable-latency instruction memory and the fetch stage of a three-stage in-order pipeline (fetch, decode, execute, one cycle each in the normal case). It runs ahead of the pipeline and requests consecutive 32-bit instruction words. It keeps doing so while execute is held by a long-running instruction, and it stores the words that come back. When the hold ends, fetch takes its next word straight from the queue instead of waiting on a fresh memory access. Each queued word travels with its own fetch address.

The queue is not a cache. It stores no tags and only ever holds the next stretch of the sequential stream. A redirect (for example a taken branch) empties the queue and marks every request still in flight so that its answer is dropped. Prefetching then starts again from the new word-aligned target. When the queue is empty and a fresh word arrives while fetch can take it, the word passes through in the same cycle.

Top module: `instr_prefetch_buf`

## Requirements
- R1: In the first cycle after synchronous reset, `fetch_valid` is low and `imem_req_valid` is high with `imem_req_addr` equal to `RESET_ADDR`.
- R2: Accepted memory requests carry addresses that rise by 4 from one request to the next. Bits [1:0] of every request address are zero. The two low bits of `redirect_addr` are ignored.
- R3: Words stored, plus live requests awaiting an answer, plus discarded requests awaiting an answer, never exceed `DEPTH`. `imem_req_valid` is low whenever that sum equals `DEPTH`.
- R4: While `stall` is high, the block keeps issuing requests and capturing answers until `DEPTH` words are stored.
- R5: A word is taken when `fetch_valid && fetch_ready && !stall`. In the first cycle after a stall that filled the queue, `fetch_valid` is high with no memory answer pending. An offered word that is not taken stays on `fetch_addr`/`fetch_word` unchanged until it is taken or a redirect occurs.
- R6: If the queue is empty and a live answer arrives while `fetch_ready` is high and `stall` is low, that word and its address appear on the fetch port in the same cycle.
- R7: In a cycle with `redirect` high, `fetch_valid` and `imem_req_valid` are low. `fetch_valid` is also low in the following cycle. All stored words and all answers to earlier requests are discarded. The next request goes to the aligned target.
- R8: Whatever the memory latency, the words delivered are the memory's answers for consecutive addresses. The addresses start at the last reset or redirect target, with no gaps or repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| redirect | input | 1 | Restart the stream at `redirect_addr` |
| redirect_addr | input | ADDR_W | New stream start (low two bits ignored) |
| stall | input | 1 | Pipeline held; no word is taken |
| imem_req_valid | output | 1 | Request to instruction memory |
| imem_req_ready | input | 1 | Memory accepts the request |
| imem_req_addr | output | ADDR_W | Word address requested |
| imem_rsp_valid | input | 1 | Memory answer, in request order |
| imem_rsp_data | input | 32 | Instruction word answered |
| fetch_valid | output | 1 | A word is offered to fetch |
| fetch_ready | input | 1 | Fetch can take a word |
| fetch_addr | output | ADDR_W | Address of the offered word |
| fetch_word | output | 32 | Offered instruction word |

## Verification
The bench builds the block with `DEPTH` = 4, per-entry address storage and a non-zero `RESET_ADDR`. A four-entry queue fills within a thirty-cycle stall even with memory latencies of one to four cycles, so the full-credit stop and the resume-from-queue path are both reached. Memory acceptance gaps every fifth cycle, together with the short depth, leave the queue empty often. This exercises the same-cycle pass-through. Redirects issued with answers still in flight, one of them twice in a row, exercise the discard count.

// File: rtl/pf_pkg.sv
package pf_pkg;
   localparam int unsigned PF_INSN_W = 32;
   localparam int unsigned PF_ALIGN  = 2;
   localparam int unsigned PF_STEP   = 4;
endpackage

// File: rtl/pf_slot_fifo.sv
module pf_slot_fifo #(
   parameter int unsigned DEPTH      = 4,
   parameter int unsigned ADDR_W     = 32,
   parameter bit          STORE_ADDR = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         flush,
   input  logic                         push,
   input  logic [ADDR_W-1:0]            push_addr,
   input  logic [pf_pkg::PF_INSN_W-1:0] push_word,
   input  logic                         pop,
   output logic [ADDR_W-1:0]            head_addr,
   output logic [pf_pkg::PF_INSN_W-1:0] head_word,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned W     = pf_pkg::PF_INSN_W;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pf_slot_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]     word_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) word_q[wr_ptr] <= push_word;
   end

   assign head_word = word_q[rd_ptr];
   assign count     = cnt_q;

   if (STORE_ADDR) begin : g_addr_slots
      logic [ADDR_W-1:0] addr_q [DEPTH];
      always_ff @(posedge clk) begin
         if (push) addr_q[wr_ptr] <= push_addr;
      end
      assign head_addr = addr_q[rd_ptr];
   end else begin : g_addr_counter
      logic [ADDR_W-1:0] head_q;
      always_ff @(posedge clk) begin
         if (rst) head_q <= '0;
         else if (cnt_q == '0 && push) head_q <= push_addr;
         else if (pop) head_q <= head_q + ADDR_W'(pf_pkg::PF_STEP);
      end
      assign head_addr = head_q;
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      (push && !pop) |-> (cnt_q != CNT_W'(DEPTH)));
   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
      pop |-> (cnt_q != '0));
   assert_no_push_on_flush_R7: assert property (@(posedge clk) disable iff (rst)
      flush |-> !push);
endmodule

// File: rtl/pf_issue_ctrl.sv
module pf_issue_ctrl #(
   parameter int unsigned       DEPTH      = 4,
   parameter int unsigned       ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       redirect,
   input  logic [ADDR_W-1:0]          redirect_addr,
   input  logic                       req_ready,
   input  logic                       rsp_valid,
   input  logic [$clog2(DEPTH+1)-1:0] stored,
   output logic                       req_valid,
   output logic [ADDR_W-1:0]          req_addr,
   output logic                       rsp_live,
   output logic [ADDR_W-1:0]          rsp_addr
);
   import pf_pkg::*;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned SUM_W = CNT_W + 2;

   if (RESET_ADDR[PF_ALIGN-1:0] != '0) begin : g_bad_reset
      $error("pf_issue_ctrl: RESET_ADDR must be word aligned");
   end

   logic [CNT_W-1:0]  live_q, drop_q;
   logic [ADDR_W-1:0] issue_q, expect_q, target;
   logic [SUM_W-1:0]  inflight;
   logic              fire, rsp_drop;

   assign target    = {redirect_addr[ADDR_W-1:PF_ALIGN], {PF_ALIGN{1'b0}}};
   assign inflight  = SUM_W'(live_q) + SUM_W'(drop_q) + SUM_W'(stored);
   assign req_valid = !redirect && (inflight < SUM_W'(DEPTH));
   assign req_addr  = issue_q;
   assign fire      = req_valid && req_ready;
   assign rsp_drop  = rsp_valid && (drop_q != '0);
   assign rsp_live  = rsp_valid && (drop_q == '0) && !redirect;
   assign rsp_addr  = expect_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         issue_q  <= RESET_ADDR;
         expect_q <= RESET_ADDR;
         live_q   <= '0;
         drop_q   <= '0;
      end else if (redirect) begin
         issue_q  <= target;
         expect_q <= target;
         live_q   <= '0;
         drop_q   <= live_q + drop_q - CNT_W'(rsp_valid);
      end else begin
         if (fire)     issue_q  <= issue_q + ADDR_W'(PF_STEP);
         if (rsp_live) expect_q <= expect_q + ADDR_W'(PF_STEP);
         live_q <= live_q + CNT_W'(fire) - CNT_W'(rsp_live);
         if (rsp_drop) drop_q <= drop_q - CNT_W'(1);
      end
   end

   assert_credit_R3: assert property (@(posedge clk) disable iff (rst)
      inflight <= SUM_W'(DEPTH));
   assert_rsp_expected_R8: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> ((live_q != '0) || (drop_q != '0)));
   assert_sequential_R2: assert property (@(posedge clk) disable iff (rst)
      fire |=> (req_addr == $past(req_addr) + ADDR_W'(PF_STEP)));
   assert_redirect_target_R7: assert property (@(posedge clk) disable iff (rst)
      redirect |=> (req_addr == $past(target)));
endmodule

// File: rtl/instr_prefetch_buf.sv
module instr_prefetch_buf #(
   parameter int unsigned       DEPTH      = 4,
   parameter int unsigned       ADDR_W     = 32,
   parameter bit                STORE_ADDR = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_0100
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              redirect,
   input  logic [ADDR_W-1:0] redirect_addr,
   input  logic              stall,
   output logic              imem_req_valid,
   input  logic              imem_req_ready,
   output logic [ADDR_W-1:0] imem_req_addr,
   input  logic              imem_rsp_valid,
   input  logic [31:0]       imem_rsp_data,
   output logic              fetch_valid,
   input  logic              fetch_ready,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [31:0]       fetch_word
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (ADDR_W < pf_pkg::PF_ALIGN + 2) begin : g_bad_addr_w
      $error("instr_prefetch_buf: ADDR_W too small");
   end

   logic [CNT_W-1:0]  stored;
   logic [ADDR_W-1:0] head_addr, rsp_addr;
   logic [31:0]       head_word;
   logic              rsp_live, take, q_empty, push, pop;

   pf_issue_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_issue (
      .clk(clk), .rst(rst), .redirect(redirect), .redirect_addr(redirect_addr),
      .req_ready(imem_req_ready), .rsp_valid(imem_rsp_valid), .stored(stored),
      .req_valid(imem_req_valid), .req_addr(imem_req_addr),
      .rsp_live(rsp_live), .rsp_addr(rsp_addr)
   );

   assign q_empty     = (stored == '0);
   assign fetch_valid = !redirect && (!q_empty || rsp_live);
   assign fetch_addr  = q_empty ? rsp_addr : head_addr;
   assign fetch_word  = q_empty ? imem_rsp_data : head_word;
   assign take        = fetch_valid && fetch_ready && !stall;
   assign push        = rsp_live && !(q_empty && take);
   assign pop         = take && !q_empty;

   pf_slot_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .STORE_ADDR(STORE_ADDR)) u_slots (
      .clk(clk), .rst(rst), .flush(redirect), .push(push), .push_addr(rsp_addr),
      .push_word(imem_rsp_data), .pop(pop), .head_addr(head_addr),
      .head_word(head_word), .count(stored)
   );

   assert_hold_offer_R5: assert property (@(posedge clk) disable iff (rst)
      (fetch_valid && !(fetch_ready && !stall)) |=>
         (redirect || (fetch_valid && $stable(fetch_addr) && $stable(fetch_word))));
   assert_flush_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      redirect |=> !fetch_valid);
   assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (rst)
      fetch_valid |-> (fetch_addr[1:0] == 2'b00));
endmodule

// File: tb/tb_instr_prefetch_buf.sv
module tb_instr_prefetch_buf;
   localparam int DEPTH = 4;
   localparam logic [31:0] RST_PC = 32'h0000_0100;

   logic clk = 1'b0, rst = 1'b1;
   logic redirect = 1'b0, stall = 1'b0, fetch_ready = 1'b0;
   logic [31:0] redirect_addr = '0;
   logic imem_req_ready = 1'b0, imem_rsp_valid = 1'b0;
   logic [31:0] imem_rsp_data = '0;
   logic imem_req_valid, fetch_valid;
   logic [31:0] imem_req_addr, fetch_addr, fetch_word;

   always #2 clk = ~clk;

   instr_prefetch_buf #(.DEPTH(DEPTH), .ADDR_W(32), .STORE_ADDR(1'b1), .RESET_ADDR(RST_PC)) dut (
      .clk(clk), .rst(rst), .redirect(redirect), .redirect_addr(redirect_addr), .stall(stall),
      .imem_req_valid(imem_req_valid), .imem_req_ready(imem_req_ready), .imem_req_addr(imem_req_addr),
      .imem_rsp_valid(imem_rsp_valid), .imem_rsp_data(imem_rsp_data),
      .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr), .fetch_word(fetch_word)
   );

   typedef struct { logic [31:0] a; int t; bit stale; } mreq_t;
   mreq_t       mq[$];
   logic [31:0] exp_q[$];
   int checks = 0, fails = 0, cyc = 0, nreq = 0, last_t = 0, pt_seen = 0, delivered = 0;
   logic [31:0] next_req = RST_PC;
   bit k_stall = 0, k_ready = 1, k_redir = 0;
   logic [31:0] k_tgt = '0;
   bit chk_first = 0, chk_resume = 0, chk_after_redir = 0;
   logic [31:0] redir_expect = '0;

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic step();
      bit cur_rv, cur_stale;
      logic [31:0] cur_a;
      int live_n, stale_n;
      @(negedge clk);
      cyc++;
      cur_rv = 0; cur_stale = 0; cur_a = '0;
      if (mq.size() > 0 && mq[0].t <= cyc) begin
         cur_rv = 1; cur_a = mq[0].a; cur_stale = mq[0].stale;
         void'(mq.pop_front());
      end
      imem_rsp_valid = cur_rv;
      imem_rsp_data  = cur_rv ? mem_word(cur_a) : 32'h0;
      imem_req_ready = (cyc % 5) != 0;
      stall = k_stall; fetch_ready = k_ready; redirect = k_redir; redirect_addr = k_tgt;
      #1;
      live_n = 0; stale_n = 0;
      foreach (mq[i]) if (mq[i].stale) stale_n++; else live_n++;
      if (chk_first) begin // R1
         chk(!fetch_valid, "R1 fetch_valid after reset", 32'(fetch_valid), 32'd0);
         chk(imem_req_valid && imem_req_addr == RST_PC, "R1 first request", imem_req_addr, RST_PC);
         chk_first = 0;
      end
      if (chk_resume) begin // R5
         chk(fetch_valid && !cur_rv && mq.size() == 0, "R5 resume from queue", 32'(fetch_valid), 32'd1);
         chk_resume = 0;
      end
      if (chk_after_redir) begin // R7
         chk(!fetch_valid, "R7 quiet after redirect", 32'(fetch_valid), 32'd0);
         if (imem_req_valid)
            chk(imem_req_addr == redir_expect, "R7 restart address", imem_req_addr, redir_expect);
         chk_after_redir = 0;
      end
      // R3: stored + live outstanding + stale outstanding
      chk(exp_q.size() + stale_n + ((cur_rv && cur_stale) ? 1 : 0) <= DEPTH, "R3 credit",
          32'(exp_q.size() + stale_n), 32'(DEPTH));
      if (k_redir) begin
         chk(!fetch_valid && !imem_req_valid, "R7 redirect cycle", {fetch_valid, imem_req_valid}, 32'd0);
      end
      if (cur_rv && !cur_stale && !k_redir && k_ready && !k_stall && exp_q.size() == live_n + 1) begin
         pt_seen++; // R6 queue empty, live answer
         chk(fetch_valid && fetch_addr == cur_a, "R6 pass-through", fetch_addr, cur_a);
      end
      if (fetch_valid && k_ready && !k_stall) begin
         if (exp_q.size() == 0) chk(0, "R8 unexpected word", fetch_addr, 32'hFFFF_FFFF);
         else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            delivered++;
            chk(fetch_addr == e && fetch_word == mem_word(e), "R8 stream order", fetch_addr, e);
         end
      end
      if (imem_req_valid && imem_req_ready && !k_redir) begin
         mreq_t m;
         chk(imem_req_addr == next_req && imem_req_addr[1:0] == 2'b00, "R2 request address",
             imem_req_addr, next_req);
         m.a = imem_req_addr;
         m.t = (last_t + 1 > cyc + 1 + (nreq % 4)) ? last_t + 1 : cyc + 1 + (nreq % 4);
         m.stale = 0;
         last_t = m.t; nreq++;
         mq.push_back(m);
         exp_q.push_back(imem_req_addr);
         next_req = imem_req_addr + 32'd4;
      end
      if (k_redir) begin
         foreach (mq[i]) mq[i].stale = 1;
         exp_q.delete();
         next_req = {k_tgt[31:2], 2'b00};
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic do_redirect(input logic [31:0] tgt);
      k_redir = 1; k_tgt = tgt;
      step();
      k_redir = 0;
      redir_expect = {tgt[31:2], 2'b00};
      chk_after_redir = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk_first = 1;
      run(60);                                 // free running, R6 and R8
      k_stall = 1; run(30);                    // R4: fill while held
      chk(exp_q.size() == DEPTH && mq.size() == 0, "R4 filled during stall",
          32'(exp_q.size()), 32'(DEPTH));
      chk(!imem_req_valid, "R3 stop when full", 32'(imem_req_valid), 32'd0);
      k_stall = 0; chk_resume = 1; run(20);
      for (int i = 0; i < 40; i++) begin       // fetch ready toggling, R5 hold
         k_ready = (i % 3) != 0; step();
      end
      k_ready = 1; run(3);
      do_redirect(32'h0000_2003);              // R7, low bits ignored (R2)
      run(40);
      run(2);
      do_redirect(32'h0000_4000);
      do_redirect(32'h0000_8008);              // back to back
      for (int i = 0; i < 60; i++) begin
         k_stall = (i % 7) < 3; step();
      end
      k_stall = 0; run(30);
      chk(pt_seen > 0, "R6 pass-through observed", 32'(pt_seen), 32'd1);
      chk(delivered > 50, "R8 words delivered", 32'(delivered), 32'd50);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule